// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block turns a CPU address into a target memory region and an offset inside that region. A small remap register chooses what appears in the boot alias window at address zero, and whether the two main flash banks swap places. It is decoded combinationally, so a change to the register changes every decode from the next cycle on.

While reset is held, the register's mode field loads a boot mode value taken from the boot-selection inputs. Software can overwrite it later through a simple register port. A separate boot option input keeps system memory aliased at zero whenever the mode would otherwise alias main flash. An access that lands in the alias window while a reserved mode is selected raises a decode error and selects no region.

Top module: `boot_remap_decoder`

## Requirements
- R1: While `rst_n` is low (synchronous, sampled on the rising clock edge), the mode field loads `boot_mode_i` and the bank-swap bit loads 0. After reset releases, a read at offset 0 returns that mode.
- R2: A read at offset 0 returns the bank-swap bit in bit 8 and the mode in bits 2:0, with every other bit zero. A read at any other offset returns zero.
- R3: A write at offset 0 loads bit 8 into bank-swap and bits 2:0 into the mode. Decodes and reads see the new value from the cycle after the write. Writes at any other offset change nothing.
- R4: `region_sel_o` has at most one bit set. Bit 0 is flash bank 1, bit 1 is flash bank 2, bit 2 is system flash, bit 3 is the external static-memory controller, bit 4 is SRAM1 and bit 5 is quad-SPI memory. When no bit is set, `region_off_o` is zero.
- R5: In the alias window [0x0, 0x100000), mode 1 selects system flash, mode 2 the static-memory controller, mode 3 SRAM1 and mode 4 quad-SPI. In each case the offset equals the address.
- R6: In mode 0 with bank-swap 0, [0x0, 0x40000) selects bank 1 with offset equal to the address. [0x80000, 0xC0000) selects bank 2 with offset equal to the address minus 0x80000. The rest of the window selects nothing.
- R7: In mode 0 with bank-swap 1, the two alias ranges of R6 exchange banks.
- R8: In the flash window, with bank-swap 0, [0x0800_0000, 0x0804_0000) selects bank 1 and [0x0804_0000, 0x0808_0000) selects bank 2. With bank-swap 1 the two ranges exchange banks. The offset is the address minus the start of its range.
- R9: Modes 5, 6 and 7 raise `dec_err_o` for any alias-window address and select no region.
- R10: With `boot_swap_opt_i` high and mode 0, the whole alias window selects system flash with offset equal to the address. Other modes are not affected.
- R11: Addresses outside the alias window and the flash window select nothing, raise no error, and give offset zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode_i | input | 3 | Boot mode loaded into the mode field during reset |
| boot_swap_opt_i | input | 1 | Boot option that keeps system memory aliased at zero |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| cpu_addr_i | input | 32 | CPU address to decode |
| region_sel_o | output | 6 | One-hot region select |
| region_off_o | output | 32 | Offset inside the selected region |
| dec_err_o | output | 1 | Alias-window access under a reserved mode |

## Verification
On every cycle, the assertions check several properties:
- the select stays at most one-hot;
- an error never comes with a select;
- reserved read bits stay zero;
- a write at offset 0 is visible in the next read;
- the mode loaded at reset matches the boot inputs;
- every flash-window address hits exactly one bank.

Which bank and which offset each range produces can only be shown by the bench's scenarios. The same holds for the boot-option override and the one-cycle latency of a write. The bench sweeps every mode code, both swap settings and both option settings, and uses addresses at each range's edges.

// File: rtl/remap_pkg.sv
package remap_pkg;
    localparam int MODE_W = 3;
    localparam int NREG   = 6;
    localparam int NBANK  = 2;
    localparam int SWAP_BIT = 8;

    localparam int REG_BANK1 = 0;
    localparam int REG_BANK2 = 1;
    localparam int REG_SYS   = 2;
    localparam int REG_EXTM  = 3;
    localparam int REG_SRAM  = 4;
    localparam int REG_QSPI  = 5;

    localparam logic [MODE_W-1:0] MODE_MAIN = 3'd0;
    localparam logic [MODE_W-1:0] MODE_SYS  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_EXTM = 3'd2;
    localparam logic [MODE_W-1:0] MODE_SRAM = 3'd3;
    localparam logic [MODE_W-1:0] MODE_QSPI = 3'd4;

    typedef struct packed {
        logic              swap;
        logic [MODE_W-1:0] mode;
    } remap_state_t;
endpackage

// File: rtl/remap_regfile.sv
module remap_regfile
    import remap_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   boot_mode_i,
    input  logic                wr_i,
    input  logic [REG_AW-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output remap_state_t        state_o
);
    remap_state_t st_d, st_q;
    logic         sel_remap;

    assign sel_remap = (addr_i == '0);

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.swap = 1'b0;
            st_d.mode = boot_mode_i;
        end else if (wr_i && sel_remap) begin
            st_d.swap = wdata_i[SWAP_BIT];
            st_d.mode = wdata_i[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_remap) begin
            rdata_o[SWAP_BIT]     = st_q.swap;
            rdata_o[MODE_W-1:0]   = st_q.mode;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/remap_alias_dec.sv
module remap_alias_dec
    import remap_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int unsigned BANK_BYTES  = 32'h0004_0000,
    parameter int unsigned ALIAS_SPAN  = 32'h0010_0000,
    parameter int unsigned ALIAS2_BASE = 32'h0008_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  remap_state_t      state_i,
    input  logic              boot_opt_i,
    output logic [NREG-1:0]   sel_o,
    output logic [ADDR_W-1:0] off_o,
    output logic              err_o
);
    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(ALIAS_SPAN);
    localparam logic [ADDR_W-1:0] BANK   = ADDR_W'(BANK_BYTES);
    localparam logic [ADDR_W-1:0] A2_LO  = ADDR_W'(ALIAS2_BASE);
    localparam logic [ADDR_W-1:0] A2_HI  = ADDR_W'(ALIAS2_BASE + BANK_BYTES);

    logic [MODE_W-1:0] eff_mode;

    always_comb begin
        sel_o    = '0;
        off_o    = '0;
        err_o    = 1'b0;
        eff_mode = state_i.mode;
        if (eff_mode == MODE_MAIN && boot_opt_i) begin
            eff_mode = MODE_SYS;
        end
        if (addr_i < SPAN) begin
            case (eff_mode)
                MODE_MAIN: begin
                    if (addr_i < BANK) begin
                        sel_o[state_i.swap ? REG_BANK2 : REG_BANK1] = 1'b1;
                        off_o = addr_i;
                    end else if (addr_i >= A2_LO && addr_i < A2_HI) begin
                        sel_o[state_i.swap ? REG_BANK1 : REG_BANK2] = 1'b1;
                        off_o = addr_i - A2_LO;
                    end
                end
                MODE_SYS:  begin sel_o[REG_SYS]  = 1'b1; off_o = addr_i; end
                MODE_EXTM: begin sel_o[REG_EXTM] = 1'b1; off_o = addr_i; end
                MODE_SRAM: begin sel_o[REG_SRAM] = 1'b1; off_o = addr_i; end
                MODE_QSPI: begin sel_o[REG_QSPI] = 1'b1; off_o = addr_i; end
                default:   err_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/remap_flash_dec.sv
module remap_flash_dec
    import remap_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int unsigned FLASH_BASE = 32'h0800_0000,
    parameter int unsigned BANK_BYTES = 32'h0004_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              swap_i,
    output logic [NREG-1:0]   sel_o,
    output logic [ADDR_W-1:0] off_o
);
    logic [NBANK-1:0] hit;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(FLASH_BASE + g * BANK_BYTES);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(FLASH_BASE + (g + 1) * BANK_BYTES);
        assign hit[g] = (addr_i >= LO) && (addr_i < HI);
    end

    always_comb begin
        sel_o = '0;
        off_o = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (hit[b]) begin
                sel_o[REG_BANK1 + (b ^ int'(swap_i))] = 1'b1;
                off_o = addr_i - ADDR_W'(FLASH_BASE + b * BANK_BYTES);
            end
        end
    end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import remap_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int          REG_AW      = 8,
    parameter int unsigned FLASH_BASE  = 32'h0800_0000,
    parameter int unsigned BANK_BYTES  = 32'h0004_0000,
    parameter int unsigned ALIAS_SPAN  = 32'h0010_0000,
    parameter int unsigned ALIAS2_BASE = 32'h0008_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          boot_mode_i,
    input  logic                boot_swap_opt_i,
    input  logic                reg_wr_i,
    input  logic [REG_AW-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    input  logic [ADDR_W-1:0]   cpu_addr_i,
    output logic [5:0]          region_sel_o,
    output logic [ADDR_W-1:0]   region_off_o,
    output logic                dec_err_o
);
    remap_state_t      state;
    logic [NREG-1:0]   a_sel, f_sel;
    logic [ADDR_W-1:0] a_off, f_off;
    logic              a_err;

    remap_regfile #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_mode_i(boot_mode_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .state_o    (state)
    );

    remap_alias_dec #(
        .ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES),
        .ALIAS_SPAN(ALIAS_SPAN), .ALIAS2_BASE(ALIAS2_BASE)
    ) u_alias (
        .addr_i    (cpu_addr_i),
        .state_i   (state),
        .boot_opt_i(boot_swap_opt_i),
        .sel_o     (a_sel),
        .off_o     (a_off),
        .err_o     (a_err)
    );

    remap_flash_dec #(
        .ADDR_W(ADDR_W), .FLASH_BASE(FLASH_BASE), .BANK_BYTES(BANK_BYTES)
    ) u_flash (
        .addr_i(cpu_addr_i),
        .swap_i(state.swap),
        .sel_o (f_sel),
        .off_o (f_off)
    );

    assign region_sel_o = a_sel | f_sel;
    assign region_off_o = a_off | f_off;
    assign dec_err_o    = a_err;
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          REG_AW     = 8,
    parameter int unsigned FLASH_BASE = 32'h0800_0000,
    parameter int unsigned BANK_BYTES = 32'h0004_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        boot_mode_i,
    input logic              reg_wr_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic [5:0]        region_sel_o,
    input logic              dec_err_o
);
    localparam logic [ADDR_W-1:0] FL_LO = ADDR_W'(FLASH_BASE);
    localparam logic [ADDR_W-1:0] FL_HI = ADDR_W'(FLASH_BASE + 2 * BANK_BYTES);

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel_o));

    // R9
    err_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> (region_sel_o == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o & ~DATA_W'(32'h0000_0107)) == '0);

    // R3
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == '0) |=>
            ((reg_addr_i != '0) || (reg_rdata_o[2:0] == $past(reg_wdata_i[2:0]))));

    // R1
    boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && reg_addr_i == '0) |-> (reg_rdata_o[2:0] == $past(boot_mode_i)));

    // R8
    flash_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr_i >= FL_LO && cpu_addr_i < FL_HI) |->
            ($countones(region_sel_o[1:0]) == 1 && !dec_err_o));
endmodule

bind boot_remap_decoder remap_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW),
    .FLASH_BASE(FLASH_BASE), .BANK_BYTES(BANK_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_mode_i (boot_mode_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cpu_addr_i  (cpu_addr_i),
    .region_sel_o(region_sel_o),
    .dec_err_o   (dec_err_o)
);

// File: tb/sim_boot_remap_decoder.sv
module sim_boot_remap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  boot_mode = 3'd3;
    logic        boot_opt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] cpu_addr = '0;
    logic [5:0]  sel;
    logic [31:0] off;
    logic        err;

    int errors = 0;
    int checks = 0;
    int m_mode = 0;
    int m_swap = 0;

    always #10 clk = ~clk;

    boot_remap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode), .boot_swap_opt_i(boot_opt),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .cpu_addr_i(cpu_addr), .region_sel_o(sel),
        .region_off_o(off), .dec_err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: region index (-1 none), offset, error, requirement tag
    task automatic model(input longint a, output int reg_idx, output longint o,
                         output bit e, output string tag);
        int md;
        reg_idx = -1; o = 0; e = 0; tag = "R11";
        if (a < 64'h10_0000) begin
            md = m_mode;
            if (md == 0 && boot_opt) begin
                md = 1; tag = "R10";
            end else if (md == 0) begin
                tag = (m_swap != 0) ? "R7" : "R6";
            end else if (md <= 4) begin
                tag = "R5";
            end else begin
                tag = "R9";
            end
            case (md)
                0: begin
                    if (a < 64'h4_0000) begin
                        reg_idx = m_swap; o = a;
                    end else if (a >= 64'h8_0000 && a < 64'hC_0000) begin
                        reg_idx = 1 - m_swap; o = a - 64'h8_0000;
                    end
                end
                1: begin reg_idx = 2; o = a; end
                2: begin reg_idx = 3; o = a; end
                3: begin reg_idx = 4; o = a; end
                4: begin reg_idx = 5; o = a; end
                default: e = 1;
            endcase
        end else if (a >= 64'h0800_0000 && a < 64'h0808_0000) begin
            tag = "R8";
            if (a < 64'h0804_0000) begin
                reg_idx = m_swap; o = a - 64'h0800_0000;
            end else begin
                reg_idx = 1 - m_swap; o = a - 64'h0804_0000;
            end
        end
    endtask

    task automatic compare();
        int     ri;
        longint eo;
        bit     ee;
        string  tg;
        logic [5:0]  es;
        logic [31:0] er;
        model(longint'(cpu_addr), ri, eo, ee, tg);
        es = (ri < 0) ? 6'd0 : 6'(1 << ri);
        er = '0;
        if (reg_addr == 8'h00) begin
            er[8]   = m_swap[0];
            er[2:0] = m_mode[2:0];
        end
        chk(reg_rdata == er, "R2", "rdata", longint'(reg_rdata), longint'(er));
        chk($countones(sel) <= 1, "R4", "onehot", longint'(sel), 0);
        chk(sel == es, tg, "sel", longint'(sel), longint'(es));
        chk(off == 32'(eo), tg, "offset", longint'(off), eo);
        chk(err == ee, tg, "err", longint'(err), longint'(ee));
    endtask

    task automatic step(input bit wr, input logic [7:0] ra, input logic [31:0] wd,
                        input logic [31:0] ca);
        @(negedge clk);
        reg_wr = wr; reg_addr = ra; reg_wdata = wd; cpu_addr = ca;
        #2;
        if (rst_n) compare();
        @(posedge clk);
        if (!rst_n) begin
            m_mode = int'(boot_mode); m_swap = 0;
        end else if (wr && ra == 8'h00) begin
            m_mode = int'(wd[2:0]); m_swap = int'(wd[8]);
        end
    endtask

    task automatic sweep();
        logic [31:0] pts [14] = '{32'h0, 32'h3_FFFC, 32'h4_0000, 32'h8_0004,
            32'hB_FFFF, 32'hC_0000, 32'hF_FFFF, 32'h10_0000, 32'h0800_0000,
            32'h0803_FFFF, 32'h0804_0010, 32'h0807_FFFF, 32'h0808_0000,
            32'h2000_0000};
        foreach (pts[i]) step(1'b0, 8'h00, 32'h0, pts[i]);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step(1'b0, 8'h00, 32'h0, 32'h100);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(reg_rdata == 32'h3, "R1", "boot mode after reset", longint'(reg_rdata), 3);
        chk(sel == 6'b01_0000, "R1", "sram alias after boot", longint'(sel), 16);
        step(1'b0, 8'h04, 32'h0, 32'h100);
        chk(reg_rdata == 32'h0, "R2", "other offset", longint'(reg_rdata), 0);
        step(1'b1, 8'h04, 32'h0000_0107, 32'h100);
        step(1'b0, 8'h00, 32'h0, 32'h100);
        chk(reg_rdata == 32'h3, "R3", "write elsewhere ignored", longint'(reg_rdata), 3);
        // write swap=1 mode=0: same-cycle decode old, next cycle new
        step(1'b1, 8'h00, 32'h0000_0100, 32'h10);
        chk(sel == 6'b01_0000, "R3", "old mode in write cycle", longint'(sel), 16);
        step(1'b0, 8'h00, 32'h0, 32'h10);
        chk(sel == 6'b00_0010, "R3", "new mode next cycle", longint'(sel), 2);
        for (int ob = 0; ob < 2; ob++) begin
            boot_opt = ob[0];
            for (int sw = 0; sw < 2; sw++) begin
                for (int md = 0; md < 8; md++) begin
                    step(1'b1, 8'h00, 32'hFFFF_FEF8 | (32'(sw) << 8) | 32'(md), 32'h0);
                    sweep();
                end
            end
        end
        boot_opt = 1'b0;
        // second reset with a different boot mode
        @(negedge clk) rst_n = 1'b0; boot_mode = 3'd0;
        repeat (2) step(1'b0, 8'h00, 32'h0, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(reg_rdata == 32'h0, "R1", "second boot mode", longint'(reg_rdata), 0);
        sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule